// File: doc/BRIEF.md
# Watchdog Timer with Level or Pulse Reset Output

This block is a watchdog timer set up through a small byte-wide register interface. Software loads an 8-bit timeout count and picks whether that count is in seconds or minutes. It then arms the timer. Both time bases come from an external 1 ms tick through two prescalers, which restart whenever the count is reloaded. A write to the time register reloads the count, and that write is the keepalive. If software stops writing it, the count runs out and the block drives an active-low reset request.

The reset request comes out in one of two forms. In level form it stays asserted until software disarms the timer. In pulse form it lasts for one of four widths, chosen by a 2-bit code. An output-enable bit gates the pin. A sticky status flag records that the watchdog expired. Only power-on reset or a write-one-to-clear from software clears this flag, so the flag survives the reset the pin causes. The timer counts only while the external device-enable input and the timer enable bit are both high.

Top module: `wdog_rst_gen`

## Requirements
- R1: After `rst`, `rst_out_n` is 1 and reads of the config (0xF5), time (0xF6) and output-control (0xF0) registers return 0.
- R2: Config register 0xF5 holds: bit 5 timer enable, bit 4 pulse form (1) or level form (0), bit 3 minutes (1) or seconds (0), bits 1:0 pulse width code. Reads return these bits, with bits 7 and 2 reading 0. Register 0xF6 reads back the last count written. Register 0xF0 bit 7 is the output enable, and its other bits read 0. A read returns data on `rdata` one clock after `rd_en`.
- R3: In seconds mode, with count N > 0, expiry comes N×TICKS_PER_SEC ticks after the timer starts running.
- R4: In minutes mode, with count N > 0, expiry comes N×SECS_PER_MIN×TICKS_PER_SEC ticks after the timer starts running.
- R5: A write to 0xF6 reloads the count and restarts both prescalers. Keepalive writes made more often than the timeout prevent expiry.
- R6: The timer runs, and can expire, only while `dev_en` is 1 and the enable bit is 1. With either one low, nothing fires and the status stays 0.
- R7: A count of 0 while the timer runs is an immediate expiry, within a few clocks.
- R8: In level form, `rst_out_n` goes low on expiry and stays low until the timer stops running. It then returns high.
- R9: In pulse form, `rst_out_n` is low for 1, 25, 125 or 5000 ticks for width codes 0, 1, 2 or 3, and then returns high while the timer stays enabled.
- R10: While the output enable (0xF0 bit 7) is 0, `rst_out_n` stays 1 even on expiry, but the status flag is still set.
- R11: Config bit 6 is the expiry status. It is set on expiry. Writing 0 to it leaves it unchanged, writing 1 clears it, and only `rst` clears it otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| tick_ms | input | 1 | One-clock pulse every millisecond |
| dev_en | input | 1 | Device enable from the configuration logic |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Register index |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, registered |
| rst_out_n | output | 1 | Active-low watchdog reset request, registered |

## Verification
The bench measures the number of ticks from arming the timer to the falling edge of the reset output, in both time units. An off-by-one prescaler would show up there as a timeout one tick or one unit away from the computed value. It measures the low time of the pulse for every width code, which would catch a width table in the wrong order or a pulse that never ends. It checks the status flag against writes of 0 and of 1, so a plain read-write flag would fail, and it checks that status still sets with the output disabled. Keepalive writes repeated just inside the timeout must hold the output high, and a count of zero must fire at once.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int REG_W = 8;
  localparam logic [REG_W-1:0] A_OUTCTL = 8'hF0;
  localparam logic [REG_W-1:0] A_CFG    = 8'hF5;
  localparam logic [REG_W-1:0] A_TIME   = 8'hF6;

  localparam int B_STS = 6;
  localparam int B_EN  = 5;
  localparam int B_PLS = 4;
  localparam int B_MIN = 3;
  localparam int B_OE  = 7;

  typedef struct packed {
    logic       en;
    logic       pulse;
    logic       minutes;
    logic [1:0] pw;
  } cfg_t;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [REG_W-1:0] addr,
  input  logic [REG_W-1:0] wdata,
  input  logic             fire_i,
  output cfg_t             cfg_o,
  output logic             oe_o,
  output logic [REG_W-1:0] time_o,
  output logic             reload_o,
  output logic             sts_o,
  output logic [REG_W-1:0] rdata_o
);
  logic wr_cfg, wr_out, clr_sts;

  assign wr_cfg   = wr_en && (addr == A_CFG);
  assign wr_out   = wr_en && (addr == A_OUTCTL);
  assign reload_o = wr_en && (addr == A_TIME);
  assign clr_sts  = wr_cfg && wdata[B_STS];

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_o  <= '0;
      oe_o   <= 1'b0;
      time_o <= '0;
      sts_o  <= 1'b0;
    end else begin
      if (wr_cfg) begin
        cfg_o.en      <= wdata[B_EN];
        cfg_o.pulse   <= wdata[B_PLS];
        cfg_o.minutes <= wdata[B_MIN];
        cfg_o.pw      <= wdata[1:0];
      end
      if (wr_out)   oe_o   <= wdata[B_OE];
      if (reload_o) time_o <= wdata;
      if (fire_i)       sts_o <= 1'b1;
      else if (clr_sts) sts_o <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_o <= '0;
    end else if (rd_en) begin
      case (addr)
        A_CFG:    rdata_o <= {1'b0, sts_o, cfg_o.en, cfg_o.pulse, cfg_o.minutes, 1'b0, cfg_o.pw};
        A_TIME:   rdata_o <= time_o;
        A_OUTCTL: rdata_o <= {oe_o, 7'b0};
        default:  rdata_o <= '0;
      endcase
    end
  end

  // R11: status is sticky unless a one is written to its bit
  assert_sticky_R11: assert property (@(posedge clk) disable iff (rst)
    (sts_o && !clr_sts) |=> sts_o);
endmodule

// File: rtl/wdog_prescale.sv
module wdog_prescale #(
  parameter int TICKS_PER_SEC = 1000,
  parameter int SECS_PER_MIN  = 60
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic run,
  input  logic restart,
  input  logic minutes,
  output logic unit_pulse
);
  localparam int MSW = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
  localparam int SSW = (SECS_PER_MIN > 1) ? $clog2(SECS_PER_MIN) : 1;
  localparam logic [MSW-1:0] MS_LAST = MSW'(TICKS_PER_SEC - 1);
  localparam logic [SSW-1:0] S_LAST  = SSW'(SECS_PER_MIN - 1);

  logic [MSW-1:0] ms_cnt;
  logic [SSW-1:0] s_cnt;
  logic sec_p, min_p;

  assign sec_p = run && tick && (ms_cnt == MS_LAST);
  assign min_p = sec_p && (s_cnt == S_LAST);
  assign unit_pulse = minutes ? min_p : sec_p;

  always_ff @(posedge clk) begin
    if (rst || restart || !run) begin
      ms_cnt <= '0;
      s_cnt  <= '0;
    end else if (tick) begin
      ms_cnt <= (ms_cnt == MS_LAST) ? '0 : ms_cnt + 1'b1;
      if (sec_p) s_cnt <= (s_cnt == S_LAST) ? '0 : s_cnt + 1'b1;
    end
  end

  // R3: millisecond prescaler never leaves its range
  assert_ms_range_R3: assert property (@(posedge clk) disable iff (rst)
    ms_cnt <= MS_LAST);
  // R4: second prescaler never leaves its range
  assert_s_range_R4: assert property (@(posedge clk) disable iff (rst)
    s_cnt <= S_LAST);
endmodule

// File: rtl/wdog_count.sv
module wdog_count #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          reload,
  input  logic [CW-1:0] load_val,
  input  logic          unit_pulse,
  output logic          fire,
  output logic          fired
);
  logic [CW-1:0] cnt;

  assign fire = run && !fired && !reload && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      fired <= 1'b0;
    end else begin
      if (reload)                              cnt <= load_val;
      else if (run && unit_pulse && cnt != '0) cnt <= cnt - 1'b1;
      if (!run)      fired <= 1'b0;
      else if (fire) fired <= 1'b1;
    end
  end

  // R6: an expiry latch only rises while the timer runs
  assert_fired_needs_run_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(fired) |-> $past(run));
endmodule

// File: rtl/wdog_outgen.sv
module wdog_outgen #(
  parameter int PW0 = 1,
  parameter int PW1 = 25,
  parameter int PW2 = 125,
  parameter int PW3 = 5000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       run,
  input  logic       fire,
  input  logic       pulse_mode,
  input  logic [1:0] pw_code,
  input  logic       oe,
  output logic       rst_n
);
  localparam int M01 = (PW0 > PW1) ? PW0 : PW1;
  localparam int M23 = (PW2 > PW3) ? PW2 : PW3;
  localparam int PMAX = (M01 > M23) ? M01 : M23;
  localparam int PCW = $clog2(PMAX + 1);

  logic lvl_hold, p_act;
  logic [PCW-1:0] pcnt, width;

  always_comb begin
    case (pw_code)
      2'd0:    width = PCW'(PW0);
      2'd1:    width = PCW'(PW1);
      2'd2:    width = PCW'(PW2);
      default: width = PCW'(PW3);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_hold <= 1'b0;
      p_act    <= 1'b0;
      pcnt     <= '0;
      rst_n    <= 1'b1;
    end else begin
      if (!run)                     lvl_hold <= 1'b0;
      else if (fire && !pulse_mode) lvl_hold <= 1'b1;
      if (fire && pulse_mode) begin
        p_act <= 1'b1;
        pcnt  <= width;
      end else if (p_act && tick) begin
        if (pcnt == PCW'(1)) begin
          p_act <= 1'b0;
          pcnt  <= '0;
        end else begin
          pcnt <= pcnt - 1'b1;
        end
      end
      rst_n <= !((lvl_hold || p_act) && oe);
    end
  end

  // R10: disabled output never drives the reset request
  assert_oe_gate_R10: assert property (@(posedge clk) disable iff (rst)
    !oe |=> rst_n);
  // R8: level hold persists while the timer keeps running
  assert_level_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (lvl_hold && run) |=> lvl_hold);
  // R9: an active pulse always has time left
  assert_pulse_live_R9: assert property (@(posedge clk) disable iff (rst)
    p_act |-> (pcnt != '0));
endmodule

// File: rtl/wdog_rst_gen.sv
module wdog_rst_gen
  import wdog_pkg::*;
#(
  parameter int TICKS_PER_SEC = 1000,
  parameter int SECS_PER_MIN  = 60,
  parameter int PW0 = 1,
  parameter int PW1 = 25,
  parameter int PW2 = 125,
  parameter int PW3 = 5000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick_ms,
  input  logic       dev_en,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [7:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       rst_out_n
);
  cfg_t cfg;
  logic oe, reload, sts, run, unit_pulse, fire, fired;
  logic [REG_W-1:0] time_val;

  assign run = dev_en && cfg.en;

  wdog_regs u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .fire_i(fire), .cfg_o(cfg), .oe_o(oe), .time_o(time_val),
    .reload_o(reload), .sts_o(sts), .rdata_o(rdata)
  );

  wdog_prescale #(.TICKS_PER_SEC(TICKS_PER_SEC), .SECS_PER_MIN(SECS_PER_MIN)) u_pre (
    .clk(clk), .rst(rst), .tick(tick_ms), .run(run), .restart(reload),
    .minutes(cfg.minutes), .unit_pulse(unit_pulse)
  );

  wdog_count #(.CW(REG_W)) u_cnt (
    .clk(clk), .rst(rst), .run(run), .reload(reload), .load_val(wdata),
    .unit_pulse(unit_pulse), .fire(fire), .fired(fired)
  );

  wdog_outgen #(.PW0(PW0), .PW1(PW1), .PW2(PW2), .PW3(PW3)) u_out (
    .clk(clk), .rst(rst), .tick(tick_ms), .run(run), .fire(fire),
    .pulse_mode(cfg.pulse), .pw_code(cfg.pw), .oe(oe), .rst_n(rst_out_n)
  );

  // R11: the status flag only rises while the timer is running
  assert_sts_source_R11: assert property (@(posedge clk) disable iff (rst)
    $rose(sts) |-> $past(run));
  // R7: after an expiry the latch is held unless the timer stopped
  assert_fired_state_R7: assert property (@(posedge clk) disable iff (rst)
    (fired && run) |=> fired);
  // R2: time register follows the last keepalive write
  assert_time_reg_R2: assert property (@(posedge clk) disable iff (rst)
    reload |=> (time_val == $past(wdata)));
endmodule

// File: tb/wdog_rst_gen_tb_top.sv
module wdog_rst_gen_tb_top;
  localparam int TPS = 20;
  localparam int SPM = 6;
  localparam int TOL = 3;

  logic clk = 1'b0, rst = 1'b1, tick_ms = 1'b1, dev_en = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] addr = '0, wdata = '0;
  logic [7:0] rdata;
  logic rst_out_n;
  int checks = 0, failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  wdog_rst_gen #(.TICKS_PER_SEC(TPS), .SECS_PER_MIN(SPM)) dut_i (
    .clk(clk), .rst(rst), .tick_ms(tick_ms), .dev_en(dev_en), .wr_en(wr_en),
    .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata), .rst_out_n(rst_out_n)
  );

  function automatic int exp_ticks(int n, bit mins);
    return n * TPS * (mins ? SPM : 1);
  endfunction

  function automatic int exp_width(int code);
    case (code)
      0: return 1;
      1: return 25;
      2: return 125;
      default: return 5000;
    endcase
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_near(string req, int act, int exp);
    checks++;
    if (act < exp - TOL || act > exp + TOL) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(posedge clk);
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic wait_low(int maxc, output int c);
    c = -1;
    for (int i = 1; i <= maxc; i++) begin
      @(negedge clk);
      if (!rst_out_n) begin c = i; break; end
    end
  endtask

  task automatic wait_high(int maxc, output int c);
    c = -1;
    for (int i = 1; i <= maxc; i++) begin
      @(negedge clk);
      if (rst_out_n) begin c = i; break; end
    end
  endtask

  task automatic idle(int n, output bit stayed_high);
    stayed_high = 1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (!rst_out_n) stayed_high = 0;
    end
  endtask

  // disarm, load count, then arm with the given config byte
  task automatic arm(logic [7:0] cnt, logic [7:0] cfg);
    wr(8'hF5, 8'h00);
    wr(8'hF6, cnt);
    wr(8'hF5, cfg);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    int c, n;
    bit hi;
    void'($urandom(32'd1234));
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R1 reset state
    chk("R1 out", int'(rst_out_n), 1);
    rd(8'hF5, d); chk("R1 cfg", d, 0);
    rd(8'hF6, d); chk("R1 time", d, 0);
    rd(8'hF0, d); chk("R1 outctl", d, 0);

    // R2 random register readback (dev_en low, nothing runs)
    for (int k = 0; k < 6; k++) begin
      logic [7:0] v, t, o;
      v = 8'($urandom); t = 8'($urandom); o = 8'($urandom);
      wr(8'hF5, v); wr(8'hF6, t); wr(8'hF0, o);
      rd(8'hF5, d); chk("R2 cfg", d, int'(v & 8'h3B));
      rd(8'hF6, d); chk("R2 time", d, int'(t));
      rd(8'hF0, d); chk("R2 outctl", d, int'(o & 8'h80));
    end

    // R6 enabled with zero count but dev_en low: no expiry
    wr(8'hF0, 8'h80);
    wr(8'hF6, 8'h00); wr(8'hF5, 8'h20);
    idle(100, hi); chk("R6 dev_en low out", int'(hi), 1);
    rd(8'hF5, d); chk("R6 dev_en low sts", int'(d[6]), 0);

    // R3 seconds timeout, level form
    dev_en = 1'b1;
    n = 1 + int'($urandom % 4);
    arm(8'(n), 8'h20);
    wait_low(exp_ticks(n, 0) + 50, c);
    chk_near("R3 seconds timeout", c, exp_ticks(n, 0));
    rd(8'hF5, d); chk("R11 sts set", int'(d[6]), 1);
    wr(8'hF5, 8'h20);
    rd(8'hF5, d); chk("R11 write0 keeps sts", int'(d[6]), 1);
    idle(60, hi); chk("R8 level held", int'(hi), 0);
    wr(8'hF5, 8'h00);
    wait_high(5, c); chk("R8 release on disable", int'(c > 0), 1);
    wr(8'hF5, 8'h40);
    rd(8'hF5, d); chk("R11 write1 clears", int'(d[6]), 0);

    // R4 minutes timeout
    arm(8'd2, 8'h28);
    wait_low(exp_ticks(2, 1) + 50, c);
    chk_near("R4 minutes timeout", c, exp_ticks(2, 1));
    wr(8'hF5, 8'h40);

    // R5 keepalive holds off expiry, then expiry after the last one
    arm(8'd3, 8'h20);
    hi = 1;
    for (int k = 0; k < 6; k++) begin
      bit h;
      idle(40, h);
      if (!h) hi = 0;
      wr(8'hF6, 8'd3);
    end
    chk("R5 keepalive no fire", int'(hi), 1);
    wait_low(exp_ticks(3, 0) + 50, c);
    chk_near("R5 expiry after last keepalive", c, exp_ticks(3, 0));
    wr(8'hF5, 8'h40);

    // R6 dev_en dropped mid-run
    arm(8'd2, 8'h20);
    dev_en = 1'b0;
    idle(200, hi); chk("R6 dev_en dropped out", int'(hi), 1);
    rd(8'hF5, d); chk("R6 dev_en dropped sts", int'(d[6]), 0);
    dev_en = 1'b1;
    wr(8'hF5, 8'h00);

    // R7 zero count fires immediately
    arm(8'd0, 8'h20);
    wait_low(10, c);
    chk("R7 immediate expiry", int'(c > 0 && c <= 4), 1);
    wr(8'hF5, 8'h40);

    // R9 pulse widths for every code
    for (int code = 0; code < 4; code++) begin
      int w;
      arm(8'd1, 8'(8'h30 | code));
      wait_low(exp_ticks(1, 0) + 50, c);
      chk_near("R9 pulse start", c, exp_ticks(1, 0));
      wait_high(exp_width(code) + 50, w);
      chk("R9 pulse width", (w >= exp_width(code) - 1 && w <= exp_width(code) + 1) ? exp_width(code) : w,
          exp_width(code));
      idle(30, hi); chk("R9 stays released", int'(hi), 1);
      wr(8'hF5, 8'h40);
    end

    // R10 output disabled: no pin activity, status still set
    wr(8'hF0, 8'h00);
    arm(8'd1, 8'h20);
    idle(exp_ticks(1, 0) + 60, hi);
    chk("R10 pin stays high", int'(hi), 1);
    rd(8'hF5, d); chk("R10 sts set", int'(d[6]), 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule